// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the state machine that decides which of five power modes a device is in and drives the enables that follow from that mode. The enables cover the core clock, the system clock, the PLL, the PLL bypass select and the core supply. The clock gates, the PLL and the regulator are not part of this block. They are driven only through these enable outputs.

Software asks for a mode change with a one-cycle request that carries a mode code. The controller checks the request against the PLL enable bit and refuses any request that is not legal. A refused request raises an error pulse and leaves the mode unchanged.

Some exits do not come from a request:
- Sleep is left on a wakeup event.
- Deep sleep and hibernate are left only through the reset pin.
- In each of these exits, the BYPASS bit picks the resume mode.

A new clock multiplier is held as pending and is applied only when full-on is entered.

Top module: `pwr_mode_seq`

## Requirements
- R1: After rst_n is released, mode_o is 0 (full-on), cclk_en, sclk_en, pll_on and vdd_en are 1, pll_bypass is 0, req_err is 0 and mult_o equals DEF_MULT.
- R2: Mode codes are 0 full-on, 1 active, 2 sleep, 3 deep sleep, 4 hibernate and 5 supply settling. The enables follow the mode:
  - cclk_en is 1 only in modes 0 and 1.
  - sclk_en is 1 only in modes 0, 1 and 2.
  - vdd_en is 0 only in mode 4.
  - pll_on is 1 in modes 0, 2 and 5, follows pll_en in mode 1, and is 0 in modes 3 and 4.
- R3: In modes 0 and 1, a legal request (req_valid with req_mode 0 to 4) sets mode_o to req_mode at the next clock edge.
- R4: A request for mode 0 or 2 while pll_en is 0 is refused. The mode is unchanged and req_err is 1 for the cycle after the request.
- R5: Other requests are also refused with req_err. This covers a request with code 5, 6 or 7, a request made in modes 2 to 5, and a request made together with pin_reset.
- R6: In mode 1, pll_bypass is 1 and pll_on equals pll_en.
- R7: mult_o takes the value of mult_pend only on an edge where the mode changes into 0 from any other mode. At all other times it holds.
- R8: In mode 2, wakeup without pin_reset moves to mode 1 if bypass is 1 and to mode 0 if bypass is 0.
- R9: Mode 3 ignores wakeup and requests. pin_reset moves it to mode 1 if bypass is 1 and to mode 0 if bypass is 0.
- R10: Hibernate is left only through pin_reset, which moves it to mode 5.
  - Mode 5 lasts SETTLE_CYC cycles with only vdd_en and pll_on set.
  - After that it moves to mode 1 if bypass is 1 and to mode 0 if bypass is 0.
- R11: pin_reset in modes 0, 1 or 2 moves to mode 0.
- R12: In mode 2, pll_bypass is 1 if sleep was entered from mode 1 and 0 if it was entered from mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Mode change request strobe |
| req_mode | input | 3 | Requested mode code |
| pll_en | input | 1 | PLL enable bit |
| bypass | input | 1 | PLL bypass bit, also selects resume mode |
| mult_pend | input | MULT_W | Pending clock multiplier |
| wakeup | input | 1 | Wakeup event |
| pin_reset | input | 1 | Reset pin, exits deep sleep and hibernate |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| pll_on | output | 1 | PLL enable |
| pll_bypass | output | 1 | PLL bypass select |
| vdd_en | output | 1 | Core supply enable |
| mode_o | output | 3 | Current mode code |
| mult_o | output | MULT_W | Applied clock multiplier |
| req_err | output | 1 | One-cycle refused-request flag |

## Verification
The bench targets the following corner cases:
- A full-on or sleep request made while the PLL is off in active mode. A wrong design would switch modes with a dead PLL.
- A multiplier written outside full-on. A wrong design would apply it at once, or never.
- Resume targets chosen by BYPASS from sleep, deep sleep and hibernate. A wrong design would resume into the wrong clocking.
- The exact length of the supply settle window. A wrong design would enable clocks before the supply is stable.

Random requests, wakeups and resets run against a model built from the requirements. This shows that wakeups and requests are ignored in deep sleep and hibernate. It also shows that the error pulse appears only for refused requests.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int MULT_W = 6,
  parameter logic [MULT_W-1:0] DEF_MULT = 10,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic              pll_en,
  input  logic              bypass,
  input  logic [MULT_W-1:0] mult_pend,
  input  logic              wakeup,
  input  logic              pin_reset,
  output logic              cclk_en,
  output logic              sclk_en,
  output logic              pll_on,
  output logic              pll_bypass,
  output logic              vdd_en,
  output logic [2:0]        mode_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              req_err
);
  localparam logic [2:0] M_FULL = 3'd0, M_ACT = 3'd1, M_SLP = 3'd2,
                         M_DEEP = 3'd3, M_HIB = 3'd4, M_SETL = 3'd5;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  logic [2:0]       mode, nxt;
  logic [CNT_W-1:0] cnt;
  logic             slp_byp;
  logic [2:0]       resume;

  wire awake    = (mode == M_FULL) || (mode == M_ACT);
  wire needs_pll = (req_mode == M_FULL) || (req_mode == M_SLP);
  wire legal    = awake && !pin_reset && (req_mode <= M_HIB) && !(needs_pll && !pll_en);
  assign resume = bypass ? M_ACT : M_FULL;

  always_comb begin
    nxt = mode;
    case (mode)
      M_FULL, M_ACT: begin
        if (pin_reset) nxt = M_FULL;
        else if (req_valid && legal) nxt = req_mode;
      end
      M_SLP: begin
        if (pin_reset) nxt = M_FULL;
        else if (wakeup) nxt = resume;
      end
      M_DEEP: if (pin_reset) nxt = resume;
      M_HIB:  if (pin_reset) nxt = M_SETL;
      M_SETL: if (cnt == CNT_LAST) nxt = resume;
      default: nxt = M_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_FULL;
      mult_o  <= DEF_MULT;
      req_err <= 1'b0;
      cnt     <= '0;
      slp_byp <= 1'b0;
    end else begin
      mode    <= nxt;
      req_err <= req_valid && !legal;
      if (nxt == M_FULL && mode != M_FULL) mult_o <= mult_pend;
      if (nxt == M_SLP && mode != M_SLP) slp_byp <= (mode == M_ACT);
      if (mode == M_SETL) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign mode_o     = mode;
  assign cclk_en    = awake;
  assign sclk_en    = awake || (mode == M_SLP);
  assign pll_on     = (mode == M_FULL) || (mode == M_SLP) || (mode == M_SETL) ||
                      ((mode == M_ACT) && pll_en);
  assign pll_bypass = (mode == M_ACT) || ((mode == M_SLP) && slp_byp);
  assign vdd_en     = (mode != M_HIB);
endmodule

module pwr_mode_seq_chk #(parameter int MULT_W = 6) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_mode,
  input logic              pll_en,
  input logic              bypass,
  input logic              wakeup,
  input logic              pin_reset,
  input logic              cclk_en,
  input logic              sclk_en,
  input logic              vdd_en,
  input logic [2:0]        mode_o,
  input logic [MULT_W-1:0] mult_o,
  input logic              req_err
);
  // R4
  pll_off_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && req_valid && !pin_reset && !pll_en && (req_mode == 3'd0 || req_mode == 3'd2))
    |=> (mode_o == 3'd1 && req_err));
  // R9
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && !pin_reset) |=> (mode_o == 3'd3));
  // R7
  mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0) |=> (mode_o != 3'd0 || $stable(mult_o)));
  // R2
  hib_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |-> (!vdd_en && !cclk_en && !sclk_en));
  // R8
  wake_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && wakeup && !pin_reset && bypass) |=> (mode_o == 3'd1));
  // R10
  hib_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && pin_reset) |=> (mode_o == 3'd5 && vdd_en && !cclk_en));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .pll_en(pll_en), .bypass(bypass), .wakeup(wakeup), .pin_reset(pin_reset),
  .cclk_en(cclk_en), .sclk_en(sclk_en), .vdd_en(vdd_en), .mode_o(mode_o),
  .mult_o(mult_o), .req_err(req_err));

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int MW = 6;
  localparam int SC = 16;
  localparam logic [MW-1:0] DM = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, pll_en = 1, bypass = 0, wakeup = 0, pin_reset = 0;
  logic [2:0] req_mode = 0;
  logic [MW-1:0] mult_pend = 0;
  logic cclk_en, sclk_en, pll_on, pll_bypass, vdd_en, req_err;
  logic [2:0] mode_o;
  logic [MW-1:0] mult_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0] e_mode = 0;
  logic [MW-1:0] e_mult = DM;
  logic e_err = 0, e_sb = 0;
  int e_cnt = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.MULT_W(MW), .DEF_MULT(DM), .SETTLE_CYC(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .pll_en(pll_en), .bypass(bypass), .mult_pend(mult_pend), .wakeup(wakeup),
    .pin_reset(pin_reset), .cclk_en(cclk_en), .sclk_en(sclk_en), .pll_on(pll_on),
    .pll_bypass(pll_bypass), .vdd_en(vdd_en), .mode_o(mode_o), .mult_o(mult_o),
    .req_err(req_err));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_en(logic [2:0] m, logic sb, logic pe);
    logic c, s, p, b, v;
    c = (m == 0 || m == 1);
    s = c || m == 2;
    p = (m == 0 || m == 2 || m == 5 || (m == 1 && pe));
    b = (m == 1) || (m == 2 && sb);
    v = (m != 4);
    return {c, s, p, b, v};
  endfunction

  function automatic logic [2:0] rsm(logic by);
    return by ? 3'd1 : 3'd0;
  endfunction

  task automatic model(logic v, logic [2:0] c, logic pe, logic by, logic wk, logic pr, logic [MW-1:0] mp);
    logic lg;
    logic [2:0] n;
    lg = (e_mode <= 1) && !pr && (c <= 4) && !((c == 0 || c == 2) && !pe);
    n = e_mode;
    case (e_mode)
      0, 1: if (pr) n = 0; else if (v && lg) n = c;
      2: if (pr) n = 0; else if (wk) n = rsm(by);
      3: if (pr) n = rsm(by);
      4: if (pr) n = 5;
      default: if (e_cnt == SC - 1) n = rsm(by);
    endcase
    e_err = v && !lg;
    if (n == 0 && e_mode != 0) e_mult = mp;
    if (n == 2 && e_mode != 2) e_sb = (e_mode == 1);
    e_cnt = (e_mode == 5) ? e_cnt + 1 : 0;
    e_mode = n;
  endtask

  task automatic step(logic v, logic [2:0] c, logic pe, logic by, logic wk, logic pr,
                      logic [MW-1:0] mp, string tag);
    req_valid = v; req_mode = c; pll_en = pe; bypass = by; wakeup = wk; pin_reset = pr;
    mult_pend = mp;
    model(v, c, pe, by, wk, pr, mp);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; wakeup = 0; pin_reset = 0;
    chk({tag, " mode"}, mode_o, e_mode);
    chk({tag, " R5 err"}, req_err, e_err);
    chk({tag, " R7 mult"}, mult_o, e_mult);
    chk({tag, " R2 enables"}, {cclk_en, sclk_en, pll_on, pll_bypass, vdd_en}, exp_en(e_mode, e_sb, pll_en));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 enables", {cclk_en, sclk_en, pll_on, pll_bypass, vdd_en}, 5'b11101);
    chk("R1 mult", mult_o, DM);
    chk("R1 err", req_err, 0);

    step(1, 1, 1, 0, 0, 0, 6'd20, "R3 to active");
    chk("R3 active", mode_o, 1);
    step(0, 0, 0, 0, 0, 0, 6'd20, "R6 pll off");
    chk("R6 pll_on", pll_on, 0);
    chk("R6 bypass", pll_bypass, 1);
    step(1, 0, 0, 0, 0, 0, 6'd20, "R4 full refused");
    chk("R4 err", req_err, 1);
    chk("R4 mode", mode_o, 1);
    step(1, 2, 0, 0, 0, 0, 6'd20, "R4 sleep refused");
    chk("R7 held", mult_o, DM);
    step(1, 0, 1, 0, 0, 0, 6'd33, "R7 full accepted");
    chk("R7 applied", mult_o, 33);
    step(1, 1, 1, 0, 0, 0, 6'd7, "R3 active again");
    step(1, 2, 1, 0, 0, 0, 6'd7, "R12 sleep from active");
    chk("R12 bypass", pll_bypass, 1);
    step(1, 0, 1, 0, 0, 0, 6'd7, "R5 req in sleep");
    chk("R5 err", req_err, 1);
    step(0, 0, 1, 0, 1, 0, 6'd7, "R8 wake to full");
    chk("R8 full", mode_o, 0);
    step(1, 2, 1, 1, 0, 0, 6'd7, "R12 sleep from full");
    chk("R12 no bypass", pll_bypass, 0);
    step(0, 0, 1, 1, 1, 0, 6'd7, "R8 wake to active");
    chk("R8 active", mode_o, 1);
    step(1, 3, 1, 0, 0, 0, 6'd7, "R3 deep");
    step(0, 0, 1, 0, 1, 0, 6'd7, "R9 wake ignored");
    chk("R9 stays", mode_o, 3);
    step(0, 0, 1, 1, 0, 1, 6'd7, "R9 reset exit");
    chk("R9 active", mode_o, 1);
    step(1, 6, 1, 0, 0, 0, 6'd7, "R5 bad code");
    chk("R5 code err", req_err, 1);
    step(0, 0, 1, 0, 0, 1, 6'd9, "R11 reset active");
    chk("R11 full", mode_o, 0);
    step(1, 4, 1, 0, 0, 0, 6'd9, "R10 hibernate");
    step(0, 0, 1, 0, 1, 0, 6'd9, "R10 wake ignored");
    chk("R10 hib", mode_o, 4);
    step(0, 0, 1, 0, 0, 1, 6'd12, "R10 reset");
    begin
      int n = 0;
      while (mode_o == 5 && n < 100) begin
        n++;
        chk("R10 settle vdd only", {cclk_en, sclk_en, vdd_en}, 3'b001);
        step(0, 0, 1, 0, 0, 0, 6'd12, "R10 settling");
      end
      chk("R10 settle length", n, SC);
      chk("R10 exit full", mode_o, 0);
    end

    for (int i = 0; i < 4000; i++) begin
      logic v, pe, by, wk, pr;
      logic [2:0] c;
      v  = ($urandom % 100) < 30;
      c  = 3'($urandom % 8);
      pe = ($urandom % 100) < 75;
      by = $urandom % 2;
      wk = ($urandom % 100) < 10;
      pr = ($urandom % 100) < 3;
      step(v, c, pe, by, wk, pr, MW'($urandom), "R3 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule